// File: doc/BRIEF.md
# Saturating Fractional Multiplier

This block is a two-stage pipelined multiplier for signed fractional and small integer operands, intended to sit beside a signal-processing datapath. One operation is issued per cycle. Each operation carries an operand pair, a mode code and a two-bit accumulator tag. Two cycles later the block returns the result together with an overflow pulse. The pulse is an 8-bit one-hot mask: bit k of the mask stands for control-flag bit 16+k of the surrounding machine, and the caller ORs it into its own flag register.

Fractional modes double the signed product so that the binary point stays in place. The single product that cannot be represented is minus one times minus one. It is detected and replaced by the largest positive value, and an overflow is raised. The integer modes clamp to the 16-bit range or wrap while still flagging. Results narrower than 64 bits sit in the low bits of the result bus, with the upper bits zero. Updating the accumulator is left to the caller.

Top module: `frac_sat_mul`

## Requirements
- R1: Every cycle in which `in_valid` is high produces exactly one cycle of `out_valid` two clock edges later, and `out_valid` is never high otherwise.
- R2: Mode 0 (Q15 to Q31) returns, in result bits 31:0, the signed product of `in_a[15:0]` and `in_b[15:0]` shifted left by one, and raises no flag.
- R3: In mode 0, when both 16-bit operands are 0x8000, the result is 0x7FFFFFFF and the mask bit indexed by `in_acc` is set.
- R4: Mode 3 (Q31 to Q63) returns the 64-bit signed product of `in_a` and `in_b` shifted left by one. When both operands are 0x80000000, it returns 0x7FFFFFFFFFFFFFFF and sets the mask bit indexed by `in_acc`.
- R5: Mode 1 (rounded Q15) returns bits 31:16 of the doubled 16-bit product plus 0x8000. For the 0x8000 by 0x8000 case it returns 0x7FFF and sets mask bit 5.
- R6: Mode 2 (Q15 high half) returns bits 31:16 of the doubled 16-bit product. For the 0x8000 by 0x8000 case it returns 0x7FFF and sets mask bit 5.
- R7: Mode 4 (signed 16-bit integer, saturating) clamps a product above 32767 to 0x7FFF and a product below -32768 to 0x8000, setting mask bit 5 when it clamps. Any other product is returned as its low 16 bits.
- R8: Mode 5 (signed 16-bit integer, wrapping) returns the low 16 bits of the product and sets mask bit 5 when the product lies outside -32768..32767.
- R9: Mode 6 (unsigned 8x16) multiplies `in_a[7:0]` by `in_b[15:0]`, clamps a product above 0xFFFF to 0xFFFF and sets mask bit 5 when it clamps.
- R10: `out_ovf_mask` has at most one bit set and is zero whenever `out_valid` is low. Mode 7 returns a zero result with no flag.
- R11: While `rst` is high and in the cycle after it, `out_valid` and `out_ovf_mask` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation issue strobe |
| in_mode | input | 3 | Mode code 0..7 |
| in_acc | input | 2 | Accumulator tag for flag placement |
| in_a | input | 32 | First operand |
| in_b | input | 32 | Second operand |
| out_valid | output | 1 | Result strobe |
| out_result | output | 64 | Result, zero-extended when narrower |
| out_ovf_mask | output | 8 | One-hot overflow mask for flag bits 23:16 |

## Verification
Directed pairs are issued in every mode. The pairs include minus one by minus one, which separates the trapped corner from an ordinary doubled product. Pairs just past each 16-bit bound distinguish clamping from wrapping and show whether the flag is raised. Pairs whose unsigned product stays within 16 bits confirm that mode 6 reads only the low byte of the first operand. Back-to-back issues with varying accumulator tags, idle gaps, and a long run of random pairs biased toward extreme values test the two-cycle alignment of the result, the strobe and the mask, and show whether the mask bit follows the tag in the accumulator modes and stays fixed at bit 5 in the others.

// File: rtl/fsm_mul_pkg.sv
`timescale 1ns/1ps
package fsm_mul_pkg;

  typedef enum logic [2:0] {
    FM_Q15_WIDE   = 3'd0,
    FM_Q15_RND    = 3'd1,
    FM_Q15_HIGH   = 3'd2,
    FM_Q31_WIDE   = 3'd3,
    FM_INT16_SAT  = 3'd4,
    FM_INT16_WRAP = 3'd5,
    FM_U8X16_SAT  = 3'd6,
    FM_NONE       = 3'd7
  } fm_mode_e;

  // modes whose overflow lands in the per-accumulator flag bits
  function automatic logic fm_is_acc(fm_mode_e m);
    return (m == FM_Q15_WIDE) || (m == FM_Q31_WIDE);
  endfunction

endpackage

// File: rtl/fmul_prod_stage.sv
`timescale 1ns/1ps
module fmul_prod_stage
  import fsm_mul_pkg::*;
#(
  parameter int SHORT_W = 16,
  parameter int BYTE_W  = 8,
  parameter int ACC_W   = 2,
  localparam int LONG_W = 2 * SHORT_W,
  localparam int WIDE_W = 2 * LONG_W,
  localparam int UPR_W  = BYTE_W + SHORT_W
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  fm_mode_e                 in_mode,
  input  logic [ACC_W-1:0]         in_acc,
  input  logic [LONG_W-1:0]        in_a,
  input  logic [LONG_W-1:0]        in_b,
  output logic                     s1_valid,
  output fm_mode_e                 s1_mode,
  output logic [ACC_W-1:0]         s1_acc,
  output logic signed [LONG_W-1:0] s1_prod_s,
  output logic signed [WIDE_W-1:0] s1_prod_w,
  output logic [UPR_W-1:0]         s1_prod_u,
  output logic                     s1_corner_s,
  output logic                     s1_corner_w
);

  localparam logic [SHORT_W-1:0] NEG_ONE_S = {1'b1, {(SHORT_W-1){1'b0}}};
  localparam logic [LONG_W-1:0]  NEG_ONE_L = {1'b1, {(LONG_W-1){1'b0}}};

  logic signed [LONG_W-1:0] a_sx, b_sx;
  logic signed [WIDE_W-1:0] a_wx, b_wx;
  logic [UPR_W-1:0]         a_ux, b_ux;
  logic signed [LONG_W-1:0] prod_s_c;
  logic signed [WIDE_W-1:0] prod_w_c;
  logic [UPR_W-1:0]         prod_u_c;

  // operand extension for each multiplier flavour
  assign a_sx = {{SHORT_W{in_a[SHORT_W-1]}}, in_a[SHORT_W-1:0]};
  assign b_sx = {{SHORT_W{in_b[SHORT_W-1]}}, in_b[SHORT_W-1:0]};
  assign a_wx = {{LONG_W{in_a[LONG_W-1]}}, in_a};
  assign b_wx = {{LONG_W{in_b[LONG_W-1]}}, in_b};
  assign a_ux = {{SHORT_W{1'b0}}, in_a[BYTE_W-1:0]};
  assign b_ux = {{BYTE_W{1'b0}}, in_b[SHORT_W-1:0]};

  assign prod_s_c = a_sx * b_sx;
  assign prod_w_c = a_wx * b_wx;
  assign prod_u_c = a_ux * b_ux;

  always_ff @(posedge clk) begin
    if (rst) s1_valid <= 1'b0;
    else     s1_valid <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (in_valid) begin
      s1_mode     <= in_mode;
      s1_acc      <= in_acc;
      s1_prod_s   <= prod_s_c;
      s1_prod_w   <= prod_w_c;
      s1_prod_u   <= prod_u_c;
      s1_corner_s <= (in_a[SHORT_W-1:0] == NEG_ONE_S) && (in_b[SHORT_W-1:0] == NEG_ONE_S);
      s1_corner_w <= (in_a == NEG_ONE_L) && (in_b == NEG_ONE_L);
    end
  end

  // R1: an issued operation reaches the middle of the pipe one edge later
  p_stage_one_r1: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> s1_valid);

  p_stage_one_idle_r1: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !s1_valid);

endmodule

// File: rtl/fmul_post_stage.sv
`timescale 1ns/1ps
module fmul_post_stage
  import fsm_mul_pkg::*;
#(
  parameter int SHORT_W    = 16,
  parameter int BYTE_W     = 8,
  parameter int ACC_W      = 2,
  parameter int FLAG_W     = 8,
  parameter int NONACC_BIT = 5,
  localparam int LONG_W = 2 * SHORT_W,
  localparam int WIDE_W = 2 * LONG_W,
  localparam int UPR_W  = BYTE_W + SHORT_W
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     s1_valid,
  input  fm_mode_e                 s1_mode,
  input  logic [ACC_W-1:0]         s1_acc,
  input  logic signed [LONG_W-1:0] s1_prod_s,
  input  logic signed [WIDE_W-1:0] s1_prod_w,
  input  logic [UPR_W-1:0]         s1_prod_u,
  input  logic                     s1_corner_s,
  input  logic                     s1_corner_w,
  output logic                     out_valid,
  output logic [WIDE_W-1:0]        out_result,
  output logic [FLAG_W-1:0]        out_mask
);

  localparam logic [SHORT_W-1:0] MAX_S   = {1'b0, {(SHORT_W-1){1'b1}}};
  localparam logic [SHORT_W-1:0] MIN_S   = {1'b1, {(SHORT_W-1){1'b0}}};
  localparam logic [SHORT_W-1:0] ONES_S  = {SHORT_W{1'b1}};
  localparam logic [LONG_W-1:0]  MAX_L   = {1'b0, {(LONG_W-1){1'b1}}};
  localparam logic [WIDE_W-1:0]  MAX_W   = {1'b0, {(WIDE_W-1){1'b1}}};
  localparam logic [LONG_W-1:0]  RND_K   = LONG_W'(1) << (SHORT_W - 1);
  localparam logic signed [LONG_W-1:0] P_HI = {{(SHORT_W+1){1'b0}}, {(SHORT_W-1){1'b1}}};
  localparam logic signed [LONG_W-1:0] P_LO = {{(SHORT_W+1){1'b1}}, {(SHORT_W-1){1'b0}}};
  localparam logic [UPR_W-1:0]   U_LIM   = {{BYTE_W{1'b0}}, {SHORT_W{1'b1}}};

  logic [LONG_W-1:0] dbl_s, rnd_s;
  logic [WIDE_W-1:0] dbl_w;
  logic              int_hi, int_lo, u_over;
  logic [FLAG_W-1:0] acc_bit, fixed_bit;
  logic [WIDE_W-1:0] res_c;
  logic              ovf_c;
  logic [FLAG_W-1:0] mask_c;

  assign dbl_s  = {s1_prod_s[LONG_W-2:0], 1'b0};
  assign rnd_s  = dbl_s + RND_K;
  assign dbl_w  = {s1_prod_w[WIDE_W-2:0], 1'b0};
  assign int_hi = s1_prod_s > P_HI;
  assign int_lo = s1_prod_s < P_LO;
  assign u_over = s1_prod_u > U_LIM;

  assign acc_bit   = FLAG_W'(1) << s1_acc;
  assign fixed_bit = FLAG_W'(1) << NONACC_BIT;

  always_comb begin
    res_c = '0;
    ovf_c = 1'b0;
    unique case (s1_mode)
      FM_Q15_WIDE: begin
        res_c[LONG_W-1:0] = s1_corner_s ? MAX_L : dbl_s;
        ovf_c             = s1_corner_s;
      end
      FM_Q15_RND: begin
        res_c[SHORT_W-1:0] = s1_corner_s ? MAX_S : rnd_s[LONG_W-1:SHORT_W];
        ovf_c              = s1_corner_s;
      end
      FM_Q15_HIGH: begin
        res_c[SHORT_W-1:0] = s1_corner_s ? MAX_S : dbl_s[LONG_W-1:SHORT_W];
        ovf_c              = s1_corner_s;
      end
      FM_Q31_WIDE: begin
        res_c = s1_corner_w ? MAX_W : dbl_w;
        ovf_c = s1_corner_w;
      end
      FM_INT16_SAT: begin
        if (int_hi)      res_c[SHORT_W-1:0] = MAX_S;
        else if (int_lo) res_c[SHORT_W-1:0] = MIN_S;
        else             res_c[SHORT_W-1:0] = s1_prod_s[SHORT_W-1:0];
        ovf_c = int_hi || int_lo;
      end
      FM_INT16_WRAP: begin
        res_c[SHORT_W-1:0] = s1_prod_s[SHORT_W-1:0];
        ovf_c              = int_hi || int_lo;
      end
      FM_U8X16_SAT: begin
        res_c[SHORT_W-1:0] = u_over ? ONES_S : s1_prod_u[SHORT_W-1:0];
        ovf_c              = u_over;
      end
      default: begin
        res_c = '0;
        ovf_c = 1'b0;
      end
    endcase
  end

  assign mask_c = !ovf_c ? '0 : (fm_is_acc(s1_mode) ? acc_bit : fixed_bit);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_mask   <= '0;
      out_result <= '0;
    end else begin
      out_valid <= s1_valid;
      out_mask  <= s1_valid ? mask_c : '0;
      if (s1_valid) out_result <= res_c;
    end
  end

  // R1: the result strobe trails the middle stage by one edge
  p_out_follows_r1: assert property (@(posedge clk) disable iff (rst)
    s1_valid |=> out_valid);

  p_out_idle_r1: assert property (@(posedge clk) disable iff (rst)
    !s1_valid |=> !out_valid);

  // R10: flag pulse is one-hot and only rides with a result
  p_mask_onehot_r10: assert property (@(posedge clk) disable iff (rst)
    $onehot0(out_mask));

  p_mask_needs_valid_r10: assert property (@(posedge clk) disable iff (rst)
    (out_mask != '0) |-> out_valid);

  // R7: a positive out-of-range integer product lands on the top code
  p_int_clamp_r7: assert property (@(posedge clk) disable iff (rst)
    (s1_valid && s1_mode == FM_INT16_SAT && s1_prod_s > P_HI)
      |=> (out_result == WIDE_W'(MAX_S)) && out_mask[NONACC_BIT]);

  // R9: an unsigned product beyond 16 bits is pinned to all ones
  p_u8_clamp_r9: assert property (@(posedge clk) disable iff (rst)
    (s1_valid && s1_mode == FM_U8X16_SAT && s1_prod_u > U_LIM)
      |=> (out_result == WIDE_W'(ONES_S)) && out_mask[NONACC_BIT]);

endmodule

// File: rtl/frac_sat_mul.sv
`timescale 1ns/1ps
module frac_sat_mul
  import fsm_mul_pkg::*;
#(
  parameter int SHORT_W    = 16,
  parameter int BYTE_W     = 8,
  parameter int ACC_W      = 2,
  parameter int FLAG_W     = 8,
  parameter int NONACC_BIT = 5,
  localparam int LONG_W = 2 * SHORT_W,
  localparam int WIDE_W = 2 * LONG_W,
  localparam int UPR_W  = BYTE_W + SHORT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [2:0]        in_mode,
  input  logic [ACC_W-1:0]  in_acc,
  input  logic [LONG_W-1:0] in_a,
  input  logic [LONG_W-1:0] in_b,
  output logic              out_valid,
  output logic [WIDE_W-1:0] out_result,
  output logic [FLAG_W-1:0] out_ovf_mask
);

  localparam logic [LONG_W-1:0] NEG_ONE_L = {1'b1, {(LONG_W-1){1'b0}}};
  localparam logic [WIDE_W-1:0] MAX_W     = {1'b0, {(WIDE_W-1){1'b1}}};

  logic                     s1_valid;
  fm_mode_e                 s1_mode;
  logic [ACC_W-1:0]         s1_acc;
  logic signed [LONG_W-1:0] s1_prod_s;
  logic signed [WIDE_W-1:0] s1_prod_w;
  logic [UPR_W-1:0]         s1_prod_u;
  logic                     s1_corner_s;
  logic                     s1_corner_w;

  fmul_prod_stage #(
    .SHORT_W (SHORT_W),
    .BYTE_W  (BYTE_W),
    .ACC_W   (ACC_W)
  ) u_prod (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .in_mode     (fm_mode_e'(in_mode)),
    .in_acc      (in_acc),
    .in_a        (in_a),
    .in_b        (in_b),
    .s1_valid    (s1_valid),
    .s1_mode     (s1_mode),
    .s1_acc      (s1_acc),
    .s1_prod_s   (s1_prod_s),
    .s1_prod_w   (s1_prod_w),
    .s1_prod_u   (s1_prod_u),
    .s1_corner_s (s1_corner_s),
    .s1_corner_w (s1_corner_w)
  );

  fmul_post_stage #(
    .SHORT_W    (SHORT_W),
    .BYTE_W     (BYTE_W),
    .ACC_W      (ACC_W),
    .FLAG_W     (FLAG_W),
    .NONACC_BIT (NONACC_BIT)
  ) u_post (
    .clk         (clk),
    .rst         (rst),
    .s1_valid    (s1_valid),
    .s1_mode     (s1_mode),
    .s1_acc      (s1_acc),
    .s1_prod_s   (s1_prod_s),
    .s1_prod_w   (s1_prod_w),
    .s1_prod_u   (s1_prod_u),
    .s1_corner_s (s1_corner_s),
    .s1_corner_w (s1_corner_w),
    .out_valid   (out_valid),
    .out_result  (out_result),
    .out_mask    (out_ovf_mask)
  );

  // R4: the wide corner is trapped end to end, flag tagged by accumulator
  p_wide_corner_r4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_mode == 3'd3 && in_a == NEG_ONE_L && in_b == NEG_ONE_L)
      |=> ##1 (out_result == MAX_W) && out_ovf_mask[$past(in_acc, 2)]);

endmodule

// File: tb/frac_sat_mul_tb_top.sv
`timescale 1ns/1ps
module frac_sat_mul_tb_top;

  localparam int CYCLE_LIMIT = 200000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [2:0]  in_mode = 3'd0;
  logic [1:0]  in_acc = 2'd0;
  logic [31:0] in_a = 32'd0;
  logic [31:0] in_b = 32'd0;
  logic        out_valid;
  logic [63:0] out_result;
  logic [7:0]  out_ovf_mask;

  int checks = 0;
  int failures = 0;

  // expected-value pipe: d1 issued last step, d2 two steps ago
  logic        d1_v = 1'b0, d2_v = 1'b0;
  logic [63:0] d1_r = '0,   d2_r = '0;
  logic [7:0]  d1_k = '0,   d2_k = '0;
  string       d1_t = "",   d2_t = "";

  always #5 clk = ~clk;

  frac_sat_mul dut_i (
    .clk          (clk),
    .rst          (rst),
    .in_valid     (in_valid),
    .in_mode      (in_mode),
    .in_acc       (in_acc),
    .in_a         (in_a),
    .in_b         (in_b),
    .out_valid    (out_valid),
    .out_result   (out_result),
    .out_ovf_mask (out_ovf_mask)
  );

  task automatic check(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic string tag_of(input logic [2:0] m, input logic [31:0] a, input logic [31:0] b);
    case (m)
      3'd0: return (a[15:0] == 16'h8000 && b[15:0] == 16'h8000) ? "R3" : "R2";
      3'd1: return "R5";
      3'd2: return "R6";
      3'd3: return "R4";
      3'd4: return "R7";
      3'd5: return "R8";
      3'd6: return "R9";
      default: return "R10";
    endcase
  endfunction

  // behavioural reference, written from the requirements
  task automatic model(input logic [2:0] m, input logic [1:0] acc, input logic [31:0] a, input logic [31:0] b,
                       output logic [63:0] r, output logic [7:0] k);
    longint sa, sb, wa, wb, p, q;
    logic c16;
    sa  = longint'($signed(a[15:0]));
    sb  = longint'($signed(b[15:0]));
    wa  = longint'($signed(a));
    wb  = longint'($signed(b));
    c16 = (a[15:0] == 16'h8000) && (b[15:0] == 16'h8000);
    r = '0;
    k = '0;
    case (m)
      3'd0: begin
        if (c16) begin r = 64'h7FFF_FFFF; k = 8'd1 << acc; end
        else begin p = sa * sb * 2; r = {32'd0, p[31:0]}; end
      end
      3'd1: begin
        if (c16) begin r = 64'h7FFF; k = 8'h20; end
        else begin q = sa * sb * 2 + 32768; r = {48'd0, q[31:16]}; end
      end
      3'd2: begin
        if (c16) begin r = 64'h7FFF; k = 8'h20; end
        else begin p = sa * sb * 2; r = {48'd0, p[31:16]}; end
      end
      3'd3: begin
        if (a == 32'h8000_0000 && b == 32'h8000_0000) begin
          r = 64'h7FFF_FFFF_FFFF_FFFF; k = 8'd1 << acc;
        end else begin
          p = wa * wb * 2; r = p;
        end
      end
      3'd4, 3'd5: begin
        p = sa * sb;
        if (p > 32767) begin
          r = (m == 3'd4) ? 64'h7FFF : {48'd0, p[15:0]}; k = 8'h20;
        end else if (p < -32768) begin
          r = (m == 3'd4) ? 64'h8000 : {48'd0, p[15:0]}; k = 8'h20;
        end else begin
          r = {48'd0, p[15:0]};
        end
      end
      3'd6: begin
        p = longint'(a[7:0]) * longint'(b[15:0]);
        if (p > 65535) begin r = 64'hFFFF; k = 8'h20; end
        else r = {48'd0, p[15:0]};
      end
      default: begin r = '0; k = '0; end
    endcase
  endtask

  // one clock: compare what was issued two steps ago, then issue
  task automatic step(input logic v, input logic [2:0] m, input logic [1:0] acc,
                      input logic [31:0] a, input logic [31:0] b);
    logic [63:0] r;
    logic [7:0]  k;
    @(negedge clk);
    check(out_valid == d2_v, "R1 valid", {63'd0, out_valid}, {63'd0, d2_v});
    check(out_ovf_mask == (d2_v ? d2_k : 8'h00), d2_v ? {d2_t, " mask"} : "R10 mask",
          {56'd0, out_ovf_mask}, {56'd0, (d2_v ? d2_k : 8'h00)});
    if (d2_v) check(out_result == d2_r, d2_t, out_result, d2_r);
    model(m, acc, a, b, r, k);
    d2_v = d1_v; d2_r = d1_r; d2_k = d1_k; d2_t = d1_t;
    d1_v = v;    d1_r = r;    d1_k = k;    d1_t = tag_of(m, a, b);
    in_valid = v; in_mode = m; in_acc = acc; in_a = a; in_b = b;
  endtask

  function automatic logic [31:0] pick32();
    case ($urandom_range(0, 9))
      0: return 32'h8000_0000;
      1: return 32'h0000_8000;
      2: return 32'h7FFF_FFFF;
      3: return 32'h0000_7FFF;
      4: return 32'hFFFF_FFFF;
      5: return 32'h0000_00FF;
      6: return 32'h0000_0001;
      default: return $urandom();
    endcase
  endfunction

  initial begin
    #(CYCLE_LIMIT * 10);
    failures++;
    $display("FAIL R1 watchdog expired actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // R11: quiet outputs during reset
    repeat (3) begin
      @(negedge clk);
      check(out_valid == 1'b0, "R11 valid", {63'd0, out_valid}, 64'd0);
      check(out_ovf_mask == 8'h00, "R11 mask", {56'd0, out_ovf_mask}, 64'd0);
    end
    rst = 1'b0;

    // R2 / R3: Q15 to Q31
    step(1, 3'd0, 2'd1, 32'h0000_4000, 32'h0000_4000);
    step(1, 3'd0, 2'd2, 32'h0000_8000, 32'h0000_8000);
    step(1, 3'd0, 2'd0, 32'h0000_8000, 32'h0000_7FFF);
    step(1, 3'd0, 2'd3, 32'hABCD_FFFF, 32'h1234_FFFF);
    step(0, 3'd0, 2'd0, 32'h0, 32'h0);
    // R5: rounded
    step(1, 3'd1, 2'd0, 32'h0000_4000, 32'h0000_0001);
    step(1, 3'd1, 2'd3, 32'h0000_8000, 32'h0000_8000);
    step(1, 3'd1, 2'd0, 32'h0000_8000, 32'h0000_7FFF);
    // R6: high half
    step(1, 3'd2, 2'd0, 32'h0000_8000, 32'h0000_8000);
    step(1, 3'd2, 2'd0, 32'h0000_C000, 32'h0000_4000);
    // R4: Q31
    step(1, 3'd3, 2'd2, 32'h8000_0000, 32'h8000_0000);
    step(1, 3'd3, 2'd1, 32'h8000_0000, 32'h7FFF_FFFF);
    step(1, 3'd3, 2'd0, 32'h4000_0000, 32'hC000_0000);
    step(1, 3'd3, 2'd3, 32'h0000_8000, 32'h0000_8000);
    // R7 / R8: integer saturate and wrap
    step(1, 3'd4, 2'd0, 32'h0000_0100, 32'h0000_0100);
    step(1, 3'd4, 2'd0, 32'h0000_8000, 32'h0000_0001);
    step(1, 3'd4, 2'd1, 32'h0000_8000, 32'h0000_7FFF);
    step(1, 3'd4, 2'd0, 32'h0000_8000, 32'h0000_FFFF);
    step(1, 3'd5, 2'd0, 32'h0000_0100, 32'h0000_0100);
    step(1, 3'd5, 2'd0, 32'h0000_8000, 32'h0000_7FFF);
    step(1, 3'd5, 2'd0, 32'h0000_00B5, 32'h0000_00B4);
    // R9: unsigned 8x16, upper bits of a ignored
    step(1, 3'd6, 2'd0, 32'h0000_00FF, 32'h0000_0101);
    step(1, 3'd6, 2'd0, 32'hFFFF_FF01, 32'h0000_FFFF);
    step(1, 3'd6, 2'd0, 32'h0000_0100, 32'h0000_FFFF);
    // R10: unused code
    step(1, 3'd7, 2'd0, 32'h8000_0000, 32'h8000_0000);

    for (int i = 0; i < 1500; i++) begin
      step(($urandom_range(0, 4) != 0), 3'($urandom_range(0, 7)), 2'($urandom_range(0, 3)),
           pick32(), pick32());
    end

    repeat (3) step(0, 3'd0, 2'd0, 32'h0, 32'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule